// File: doc/BRIEF.md
# E1 Sa-Bit Receive Capture Stack

This block gathers the national-use bits (Sa4 to Sa8) carried in time slot 0 of a received E1 stream. It builds a five-word, 16-bit stack that spans two complete multiframes. A frame aligner upstream supplies the inputs on the line clock: a strobe marking each time-slot-0 byte, that byte, the frame number within the multiframe, the basic and CRC-4 multiframe alignment flags, and loss of frame. The aligner also drives two mode inputs that select which alignment flag gates the capture.

When two multiframes have been collected with no loss of alignment, the finished stack is published. It crosses to the processor clock domain with a toggle handshake and lands in a shadow register set there. A sticky ready flag then rises, and the host reads the shadow words through a small register port. A partial stack cut short by loss of frame is never published. Capture begins again at the next multiframe boundary. If a new stack completes before the host has cleared ready, an overrun flag is raised and the newest stack replaces the old one.

Top module: `sa_capture_stack`

## Requirements
- R1: After reset, `irq_ready` and `ovr_flag` are 0 and every host read (addresses 0 to 5) returns 0.
- R2: Only strobes with an odd `frame_num` contribute bits. Sa4..Sa8 are `ts0_byte` bits 4, 3, 2, 1, 0, with bit 7 the first bit on the line. Bytes of even frames leave the stack unchanged.
- R3: Word k (address k, 0..4) holds Sa(4+k). The bit from odd frame f of the m-th collected multiframe (m = 0 or 1) lands at bit 15 - (8*m + (f-1)/2), so the first bit captured sits at bit 15.
- R4: A stack starts only at a strobe with `frame_num` = 0 while aligned. Odd-frame strobes seen before that start are not captured.
- R5: The alignment flag is `bfa_ok` when `crc4_mode` = 0. It is `mfa_ok` when `crc4_mode` = 1 and `crc4_early` = 0. It is `bfa_ok` when `crc4_mode` = 1 and `crc4_early` = 1. Capture proceeds only while that flag is 1.
- R6: If `lof` is 1, or the selected alignment flag drops, while a stack is being built, the partial stack is discarded and never published. A fresh stack starts at the next frame-0 strobe.
- R7: When the frame-15 strobe of the second multiframe is taken, the five words are copied to the host shadow and `irq_ready` is set. It stays set until the host clears it.
- R8: A host write to address 5 clears `irq_ready` when `host_wdata[0]` = 1 and clears `ovr_flag` when `host_wdata[1]` = 1. A 0 bit leaves its flag unchanged, and a completion in the same cycle wins over the clear.
- R9: If a stack completes while `irq_ready` is already 1, `ovr_flag` is set and the shadow holds the newer stack.
- R10: `host_rdata` is registered and is updated one host clock after a `host_rd` cycle. Addresses 0..4 return the words, address 5 returns {ovr_flag, irq_ready} in bits 1:0, and other addresses return 0. Without a read, `host_rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Receive line clock |
| line_rst | input | 1 | Synchronous active-high reset, line domain |
| ts0_valid | input | 1 | One-cycle strobe marking a time-slot-0 byte |
| ts0_byte | input | 8 | Time-slot-0 byte, bit 7 first on the line |
| frame_num | input | 4 | Frame number 0..15 within the multiframe |
| bfa_ok | input | 1 | Basic frame alignment held |
| mfa_ok | input | 1 | CRC-4 multiframe alignment held |
| lof | input | 1 | Loss of frame |
| crc4_mode | input | 1 | 1 = CRC-4 framing, 0 = basic framing |
| crc4_early | input | 1 | In CRC-4 mode, gate capture on basic alignment only |
| host_clk | input | 1 | Processor clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 2 | Write data for the status clear bits |
| host_rdata | output | 16 | Registered read data |
| irq_ready | output | 1 | Sticky stack-ready interrupt |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench drives random time-slot-0 bytes, including random bytes in even frames. A design that sampled every frame, or that reversed the bit order inside a word, would return words that do not match the scoreboard. Loss of frame is pulsed late in the second multiframe, and alignment is withheld for one whole stack. A design that published partial data, or that failed to restart cleanly at the next frame 0, would produce an unexpected or shifted stack. Capture is also started mid-multiframe, and CRC-4 mode is run both with and without the early-start option, which catches a wrong choice of alignment source. Two stacks are left unread to force an overrun. The status clears are then exercised one bit at a time, which exposes a clear that hits both flags or a shadow that kept the older stack.

// File: rtl/sa_stack_pkg.sv
package sa_stack_pkg;
  localparam int SA_COUNT  = 5;
  localparam int WORD_BITS = 16;
  localparam int TS0_BITS  = 8;
  localparam int FN_BITS   = 4;
  localparam int FRAMES    = 16;
  localparam int SA_TOP    = 4;            // bit index of Sa4 in the byte
  localparam int STATUS_ADDR = SA_COUNT;

  typedef logic [WORD_BITS-1:0] sa_word_t;
  typedef sa_word_t [SA_COUNT-1:0] sa_stack_t;
endpackage

// File: rtl/sa_align_gate.sv
module sa_align_gate (
  input  logic crc4_mode,
  input  logic crc4_early,
  input  logic bfa_ok,
  input  logic mfa_ok,
  input  logic lof,
  output logic aligned
);
  logic use_mfa;
  logic src_ok;

  assign use_mfa = crc4_mode && !crc4_early;
  assign src_ok  = use_mfa ? mfa_ok : bfa_ok;
  assign aligned = src_ok && !lof;
endmodule

// File: rtl/sa_bit_extract.sv
module sa_bit_extract
  import sa_stack_pkg::*;
(
  input  logic [TS0_BITS-1:0] byte_in,
  output logic [SA_COUNT-1:0] sa
);
  logic unused_hi;
  assign unused_hi = ^byte_in[TS0_BITS-1:SA_TOP+1];

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
    assign sa[k] = byte_in[SA_TOP-k];
  end
endmodule

// File: rtl/sa_line_collect.sv
module sa_line_collect
  import sa_stack_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [FN_BITS-1:0] fnum,
  input  logic               aligned,
  input  logic [SA_COUNT-1:0] sa,
  output logic               busy,
  output sa_stack_t          done_data,
  output logic               done_tgl
);
  localparam int POS_W = $clog2(WORD_BITS);
  localparam logic [POS_W-1:0]   TOP_POS = POS_W'(WORD_BITS-1);
  localparam logic [FN_BITS-1:0] LAST_FN = FN_BITS'(FRAMES-1);

  logic             second;
  sa_stack_t        acc;
  sa_stack_t        acc_nxt;
  logic [POS_W-1:0] pos;
  logic             at_start;
  logic             odd_hit;

  assign pos      = TOP_POS - {second, fnum[FN_BITS-1:1]};
  assign at_start = strobe && (fnum == '0);
  assign odd_hit  = strobe && busy && fnum[0];

  always_comb begin
    acc_nxt = acc;
    for (int k = 0; k < SA_COUNT; k++) begin
      acc_nxt[k][pos] = sa[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      second    <= 1'b0;
      acc       <= '0;
      done_data <= '0;
      done_tgl  <= 1'b0;
    end else if (!aligned) begin
      busy   <= 1'b0;
      second <= 1'b0;
    end else if (at_start) begin
      if (busy && !second) begin
        second <= 1'b1;
      end else begin
        busy   <= 1'b1;
        second <= 1'b0;
        acc    <= '0;
      end
    end else if (odd_hit) begin
      acc <= acc_nxt;
      if (second && fnum == LAST_FN) begin
        done_data <= acc_nxt;
        done_tgl  <= ~done_tgl;
        busy      <= 1'b0;
        second    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sa_toggle_sync.sv
module sa_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[STAGES-1:0], tgl_in};
  end

  assign pulse = q[STAGES] ^ q[STAGES-1];
endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
  import sa_stack_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  sa_stack_t         src,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        wdata,
  output logic [WORD_BITS-1:0] rdata,
  output logic              ready,
  output logic              ovr
);
  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_ADDR);

  sa_stack_t shadow;
  logic      clr_hit;

  assign clr_hit = wr && (addr == ST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      ready  <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (load) shadow <= src;

      if (load)                     ready <= 1'b1;
      else if (clr_hit && wdata[0]) ready <= 1'b0;

      if (load && ready)            ovr <= 1'b1;
      else if (clr_hit && wdata[1]) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (int'(addr) < SA_COUNT)
        rdata <= shadow[addr];
      else if (addr == ST_ADDR)
        rdata <= {{(WORD_BITS-2){1'b0}}, ovr, ready};
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/sa_capture_stack.sv
module sa_capture_stack
  import sa_stack_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                 line_clk,
  input  logic                 line_rst,
  input  logic                 ts0_valid,
  input  logic [TS0_BITS-1:0]  ts0_byte,
  input  logic [FN_BITS-1:0]   frame_num,
  input  logic                 bfa_ok,
  input  logic                 mfa_ok,
  input  logic                 lof,
  input  logic                 crc4_mode,
  input  logic                 crc4_early,
  input  logic                 host_clk,
  input  logic                 host_rst,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [1:0]           host_wdata,
  output logic [WORD_BITS-1:0] host_rdata,
  output logic                 irq_ready,
  output logic                 ovr_flag
);
  logic                aligned;
  logic [SA_COUNT-1:0] sa_bits;
  logic                collect_busy;
  sa_stack_t           done_data;
  logic                done_tgl;
  logic                load_pulse;

  sa_align_gate u_gate (
    .crc4_mode (crc4_mode),
    .crc4_early(crc4_early),
    .bfa_ok    (bfa_ok),
    .mfa_ok    (mfa_ok),
    .lof       (lof),
    .aligned   (aligned)
  );

  sa_bit_extract u_extract (
    .byte_in(ts0_byte),
    .sa     (sa_bits)
  );

  sa_line_collect u_collect (
    .clk      (line_clk),
    .rst      (line_rst),
    .strobe   (ts0_valid),
    .fnum     (frame_num),
    .aligned  (aligned),
    .sa       (sa_bits),
    .busy     (collect_busy),
    .done_data(done_data),
    .done_tgl (done_tgl)
  );

  sa_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (host_clk),
    .rst   (host_rst),
    .tgl_in(done_tgl),
    .pulse (load_pulse)
  );

  sa_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk  (host_clk),
    .rst  (host_rst),
    .load (load_pulse),
    .src  (done_data),
    .addr (host_addr),
    .rd   (host_rd),
    .wr   (host_wr),
    .wdata(host_wdata),
    .rdata(host_rdata),
    .ready(irq_ready),
    .ovr  (ovr_flag)
  );
endmodule

// File: rtl/sa_capture_stack_chk.sv
module sa_capture_stack_chk #(
  parameter int ADDR_W = 3
) (
  input logic              line_clk,
  input logic              line_rst,
  input logic              ts0_valid,
  input logic [3:0]        frame_num,
  input logic              lof,
  input logic              collect_busy,
  input logic              done_tgl,
  input logic              host_clk,
  input logic              host_rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [1:0]        host_wdata,
  input logic [15:0]       host_rdata,
  input logic              irq_ready,
  input logic              ovr_flag
);
  logic clr_rdy;
  logic clr_ovr;
  assign clr_rdy = host_wr && (host_addr == ADDR_W'(5)) && host_wdata[0];
  assign clr_ovr = host_wr && (host_addr == ADDR_W'(5)) && host_wdata[1];

  // R6
  lof_discard_chk: assert property (@(posedge line_clk) disable iff (line_rst)
    lof |=> !collect_busy);

  // R7
  publish_at_last_chk: assert property (@(posedge line_clk) disable iff (line_rst)
    !$stable(done_tgl) |-> $past(ts0_valid && frame_num == 4'd15));

  // R7
  ready_sticky_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    (irq_ready && !clr_rdy) |=> irq_ready);

  // R8
  ovr_sticky_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    (ovr_flag && !clr_ovr) |=> ovr_flag);

  // R9
  ovr_needs_ready_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    $rose(ovr_flag) |-> $past(irq_ready));

  // R10
  rdata_hold_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind sa_capture_stack sa_capture_stack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .line_clk    (line_clk),
  .line_rst    (line_rst),
  .ts0_valid   (ts0_valid),
  .frame_num   (frame_num),
  .lof         (lof),
  .collect_busy(collect_busy),
  .done_tgl    (done_tgl),
  .host_clk    (host_clk),
  .host_rst    (host_rst),
  .host_addr   (host_addr),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .irq_ready   (irq_ready),
  .ovr_flag    (ovr_flag)
);

// File: tb/sa_capture_stack_bench.sv
module sa_capture_stack_bench;
  logic line_clk = 0;
  logic host_clk = 0;
  always #10 line_clk = ~line_clk;   // 50 MHz line clock
  always #15 host_clk = ~host_clk;

  logic line_rst, host_rst;
  logic ts0_valid;
  logic [7:0] ts0_byte;
  logic [3:0] frame_num;
  logic bfa_ok, mfa_ok, lof, crc4_mode, crc4_early;
  logic [2:0] host_addr;
  logic host_rd, host_wr;
  logic [1:0] host_wdata;
  logic [15:0] host_rdata;
  logic irq_ready, ovr_flag;

  // two host bus drivers, muxed so each variable has one writer
  logic mon_en;
  logic [2:0] m_addr, t_addr;
  logic m_rd, t_rd, m_wr, t_wr;
  logic [1:0] m_wd, t_wd;
  assign host_addr  = mon_en ? m_addr : t_addr;
  assign host_rd    = mon_en ? m_rd   : t_rd;
  assign host_wr    = mon_en ? m_wr   : t_wr;
  assign host_wdata = mon_en ? m_wd   : t_wd;

  sa_capture_stack u_sa_capture_stack (
    .line_clk(line_clk), .line_rst(line_rst), .ts0_valid(ts0_valid),
    .ts0_byte(ts0_byte), .frame_num(frame_num), .bfa_ok(bfa_ok),
    .mfa_ok(mfa_ok), .lof(lof), .crc4_mode(crc4_mode), .crc4_early(crc4_early),
    .host_clk(host_clk), .host_rst(host_rst), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_ready(irq_ready), .ovr_flag(ovr_flag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [79:0] exp_q[$];
  logic [79:0] last_exp;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- line driver ----------------
  task automatic drive_frame(input logic [3:0] fn, input logic [7:0] b, input logic lofv);
    @(negedge line_clk);
    frame_num = fn; ts0_byte = b; lof = lofv; ts0_valid = 1'b1;
    @(negedge line_clk);
    ts0_valid = 1'b0;
    repeat (3) @(negedge line_clk);
  endtask

  // 32 frames; push the expected stack just before its last strobe
  task automatic send_stack(input bit push_it, input int lof_at);
    logic [79:0] e = '0;
    for (int i = 0; i < 32; i++) begin
      logic [3:0] fn = 4'(i % 16);
      int m = i / 16;
      logic [7:0] b = 8'($urandom);
      if (fn[0]) begin
        for (int k = 0; k < 5; k++)
          e[k*16 + (15 - (m*8 + int'(fn)/2))] = b[4-k];
      end
      if (i == 31 && push_it && lof_at < 0) exp_q.push_back(e);
      drive_frame(fn, b, i == lof_at);
    end
    lof = 1'b0;
    last_exp = e;
  endtask

  // ---------------- host access ----------------
  task automatic t_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge host_clk); t_addr = a; t_rd = 1'b1;
    @(negedge host_clk); t_rd = 1'b0; d = host_rdata;
  endtask

  task automatic t_write(input logic [1:0] wd);
    @(negedge host_clk); t_addr = 3'd5; t_wd = wd; t_wr = 1'b1;
    @(negedge host_clk); t_wr = 1'b0;
  endtask

  task automatic m_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge host_clk); m_addr = a; m_rd = 1'b1;
    @(negedge host_clk); m_rd = 1'b0; d = host_rdata;
  endtask

  // ---------------- monitor / scoreboard ----------------
  initial begin
    m_addr = 0; m_rd = 0; m_wr = 0; m_wd = 0;
    forever begin
      @(negedge host_clk);
      if (mon_en && irq_ready) begin
        logic [79:0] e;
        logic [15:0] d;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected stack published", 16'h1, 16'h0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
        end
        for (int k = 0; k < 5; k++) begin
          m_read(3'(k), d);
          chk(d == e[k*16 +: 16], "R3 stack word", d, e[k*16 +: 16]);
        end
        @(negedge host_clk); m_addr = 3'd5; m_wd = 2'b01; m_wr = 1'b1;
        @(negedge host_clk); m_wr = 1'b0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 16'h0, 16'h0);
    finish_run();
  end

  task automatic host_wait(input int n);
    repeat (n) @(negedge host_clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] d;
    line_rst = 1; host_rst = 1; ts0_valid = 0; ts0_byte = 0; frame_num = 0;
    bfa_ok = 0; mfa_ok = 0; lof = 0; crc4_mode = 0; crc4_early = 0;
    t_addr = 0; t_rd = 0; t_wr = 0; t_wd = 0; mon_en = 0;
    repeat (4) @(negedge host_clk);
    line_rst = 0; host_rst = 0;
    host_wait(2);

    // R1 reset state
    chk(irq_ready == 0, "R1 ready after reset", 16'(irq_ready), 16'h0);
    chk(ovr_flag == 0, "R1 overrun after reset", 16'(ovr_flag), 16'h0);
    t_read(3'd0, d); chk(d == 0, "R1 word0 after reset", d, 16'h0);
    t_read(3'd5, d); chk(d == 0, "R1 status after reset", d, 16'h0);
    t_read(3'd7, d); chk(d == 0, "R10 unmapped address", d, 16'h0);

    mon_en = 1;
    // R2 R3 R5 basic mode, random bytes in all frames
    bfa_ok = 1;
    send_stack(1, -1);
    send_stack(1, -1);
    send_stack(1, -1);

    // R6 loss of frame late in second multiframe, then restart
    send_stack(0, 25);
    send_stack(1, -1);

    // R5 R6 no alignment for a whole stack
    bfa_ok = 0;
    send_stack(0, -1);
    bfa_ok = 1;
    // R4 start mid multiframe: frames 5..15 ignored
    for (int f = 5; f < 16; f++) drive_frame(4'(f), 8'($urandom), 1'b0);
    send_stack(1, -1);

    // R5 CRC-4 mode waits for multiframe alignment
    crc4_mode = 1; crc4_early = 0; mfa_ok = 0;
    send_stack(0, -1);
    mfa_ok = 1;
    send_stack(1, -1);
    // R5 CRC-4 early start on basic alignment
    mfa_ok = 0; crc4_early = 1;
    send_stack(1, -1);
    host_wait(20);
    chk(exp_q.size() == 0, "R7 all expected stacks seen", 16'(exp_q.size()), 16'h0);
    chk(irq_ready == 0, "R5 no stack without multiframe alignment", 16'(irq_ready), 16'h0);

    // R9 overrun: two stacks without host service
    mon_en = 0;
    crc4_mode = 0; crc4_early = 0;
    send_stack(0, -1);
    send_stack(0, -1);
    host_wait(20);
    chk(irq_ready == 1, "R7 ready set", 16'(irq_ready), 16'h1);
    chk(ovr_flag == 1, "R9 overrun set", 16'(ovr_flag), 16'h1);
    for (int k = 0; k < 5; k++) begin
      t_read(3'(k), d);
      chk(d == last_exp[k*16 +: 16], "R9 shadow holds newest stack", d, last_exp[k*16 +: 16]);
    end
    t_read(3'd5, d); chk(d == 16'h3, "R10 status read", d, 16'h3);
    t_write(2'b00);
    t_read(3'd5, d); chk(d == 16'h3, "R8 zero write ignored", d, 16'h3);
    t_write(2'b01);
    t_read(3'd5, d); chk(d == 16'h2, "R8 clear ready only", d, 16'h2);
    t_write(2'b10);
    t_read(3'd5, d); chk(d == 16'h0, "R8 clear overrun", d, 16'h0);

    // back to scoreboard for one more stack
    mon_en = 1;
    send_stack(1, -1);
    host_wait(30);
    chk(exp_q.size() == 0, "R7 final stack seen", 16'(exp_q.size()), 16'h0);
    chk(ovr_flag == 0, "R9 no overrun when serviced", 16'(ovr_flag), 16'h0);
    finish_run();
  end
endmodule